// File: doc/BRIEF.md
# Custom-Instruction Accelerator with Local Register File

This block is an accelerator that sits on a processor's dedicated instruction-extension port instead of the shared on-chip bus. The processor raises `go` for one cycle with a function code and the operand routing for one instruction. The block then runs the selected operation for a number of cycles that depends on the operation. It reports completion with a one-cycle `fin` pulse and presents the value on `res`.

Operand A and operand B are routed independently. Each one is taken either from the processor's data port or from a 32-entry by 32-bit register file kept inside the block. The result always appears on `res`, and it can also be stored in a local register. Any mix of operand sources and destination is allowed. Examples are two local inputs with the result returned to the processor, or two processor inputs with the result kept locally.

`ce` freezes the whole block. The processor holds it high only while one of its extension instructions is in flight, so every low cycle stretches the operation by one cycle.

Top module: `ci_accel`

## Requirements
- R1: An asserted `rst_n` (low) clears every local register to zero, returns the controller to idle, drives `fin` low and clears `res` to zero.
- R2: Function code 0x00 (add) returns `(A + B) mod 2^32`, with `fin` high in the first cycle after the clock edge that accepted `go`.
- R3: Function code 0x01 (multiply) returns the low 32 bits of `A * B`, with `fin` high 3 cycles after the accepting edge.
- R4: Function code 0x02 (accumulate-shift) takes k = B[5:0] and returns the sum of `A << i` for i = 0 .. k-1, modulo 2^32. `fin` is high max(k,1) cycles after the accepting edge, so k = 0 gives result 0 after 1 cycle.
- R5: Any other function code returns 0, with `fin` high 1 cycle after the accepting edge.
- R6: The operand routing bits work as follows. When `sel_a_ext` is 1, operand A is taken from `op_a_ext`. When it is 0, operand A is taken from local register `idx_a`. `sel_b_ext`, `op_b_ext` and `idx_b` route operand B in the same way.
- R7: With `dst_ext` at 0, the result is written into local register `idx_d` at the edge that raises `fin`. With `dst_ext` at 1, no local register changes. The result is on `res` in both cases.
- R8: `fin` is high for exactly one cycle per instruction. `res` stays unchanged from the `fin` cycle until the next accepted `go`.
- R9: While `ce` is low, no register changes and `go` is ignored. Each low cycle during an operation delays `fin` by one cycle.
- R10: Operands are captured at the accepting edge. Changes to `op_a_ext`/`op_b_ext` after that edge do not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable, high while an instruction is active |
| go | input | 1 | Start request, one cycle, accepted when idle and `ce` is high |
| func | input | 8 | Operation selector, captured with `go` |
| op_a_ext | input | 32 | Operand A from the processor |
| op_b_ext | input | 32 | Operand B from the processor |
| idx_a | input | 5 | Local register index for operand A |
| idx_b | input | 5 | Local register index for operand B |
| idx_d | input | 5 | Local register index for the result |
| sel_a_ext | input | 1 | 1: operand A from port, 0: from local register |
| sel_b_ext | input | 1 | 1: operand B from port, 0: from local register |
| dst_ext | input | 1 | 1: result to port only, 0: also into local register |
| fin | output | 1 | One-cycle completion pulse |
| res | output | 32 | Result, held until the next start |

## Verification
Each instruction's result is due a fixed number of cycles after the edge that accepts `go`:
- 1 cycle for add and unknown codes,
- 3 cycles for multiply,
- max(k,1) cycles for accumulate-shift,
- plus one cycle for every cycle `ce` is held low in between.

The driver records the cycle number of the accepting edge and the expected latency together with the expected value. The monitor, sampling on falling edges, compares both the value and the elapsed cycle count when `fin` appears. In the cycle after `fin`, the monitor checks that the pulse has ended and that `res` has held. Local-register contents are brought out through add instructions that read them back.

// File: rtl/ci_pkg.sv
package ci_pkg;
  localparam int FUNC_W = 8;
  localparam logic [FUNC_W-1:0] FN_ADD = 8'h00;
  localparam logic [FUNC_W-1:0] FN_MUL = 8'h01;
  localparam logic [FUNC_W-1:0] FN_ACC = 8'h02;

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} ctl_state_t;
endpackage

// File: rtl/ci_regfile.sv
module ci_regfile #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [IDX_W-1:0] rd_idx_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output logic [XLEN-1:0]  rd_a,
  output logic [XLEN-1:0]  rd_b,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data
);
  logic [DEPTH-1:0][XLEN-1:0] regs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              regs <= '0;
    else if (ce && wr_en)    regs[wr_idx] <= wr_data;
  end

  assign rd_a = regs[rd_idx_a];
  assign rd_b = regs[rd_idx_b];

  AST_RF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && wr_en) |=> regs[$past(wr_idx)] == $past(wr_data)); // R7
  AST_RF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(regs)); // R9
endmodule

// File: rtl/ci_datapath.sv
module ci_datapath
  import ci_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ITER_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [FUNC_W-1:0] func_q,
  input  logic [XLEN-1:0]   opa_in,
  input  logic [XLEN-1:0]   opb_in,
  output logic [XLEN-1:0]   final_res
);
  logic [XLEN-1:0]   opa_q, opb_q, acc_q, sh_q;
  logic [ITER_W-1:0] left_q;
  logic [XLEN-1:0]   opa_n, opb_n, acc_n, sh_n;
  logic [ITER_W-1:0] left_n;
  logic [XLEN-1:0]   prod;

  always_comb begin
    opa_n = opa_q; opb_n = opb_q; acc_n = acc_q; sh_n = sh_q; left_n = left_q;
    if (load) begin
      opa_n  = opa_in;
      opb_n  = opb_in;
      acc_n  = '0;
      sh_n   = opa_in;
      left_n = opb_in[ITER_W-1:0];
    end else if (step && left_q != '0) begin
      acc_n  = acc_q + sh_q;
      sh_n   = sh_q << 1;
      left_n = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q <= '0; opb_q <= '0; acc_q <= '0; sh_q <= '0; left_q <= '0;
    end else begin
      opa_q <= opa_n; opb_q <= opb_n; acc_q <= acc_n; sh_q <= sh_n; left_q <= left_n;
    end
  end

  assign prod = opa_q * opb_q;

  always_comb begin
    case (func_q)
      FN_ADD:  final_res = opa_q + opb_q;
      FN_MUL:  final_res = prod;
      FN_ACC:  final_res = (left_q != '0) ? acc_q + sh_q : acc_q;
      default: final_res = '0;
    endcase
  end

  AST_OPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(opa_q) && $stable(opb_q)); // R10
  AST_ITER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(left_q) && $stable(acc_q)); // R9
endmodule

// File: rtl/ci_ctrl.sv
module ci_ctrl
  import ci_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int IDX_W   = 5,
  parameter int ITER_W  = 6,
  parameter int MUL_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              go,
  input  logic [FUNC_W-1:0] func,
  input  logic [ITER_W-1:0] iter_k,
  input  logic              dst_ext,
  input  logic [IDX_W-1:0]  idx_d,
  input  logic [XLEN-1:0]   final_res,
  output logic              load,
  output logic              step,
  output logic [FUNC_W-1:0] func_q,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              fin,
  output logic [XLEN-1:0]   res
);
  ctl_state_t        state_q, state_n;
  logic [ITER_W-1:0] cnt_q, cnt_n, lat_m1;
  logic              fin_n, dext_q, dext_n;
  logic [XLEN-1:0]   res_n;
  logic [FUNC_W-1:0] func_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              last;

  always_comb begin
    case (func)
      FN_MUL:  lat_m1 = ITER_W'(MUL_LAT - 1);
      FN_ACC:  lat_m1 = (iter_k == '0) ? '0 : iter_k - 1'b1;
      default: lat_m1 = '0;
    endcase
  end

  assign load  = ce && go && (state_q == ST_IDLE);
  assign step  = ce && (state_q == ST_BUSY);
  assign last  = (state_q == ST_BUSY) && (cnt_q == '0);
  assign wr_en = last && !dext_q;
  assign wr_idx = idx_q;

  always_comb begin
    state_n = state_q; cnt_n = cnt_q; fin_n = 1'b0; res_n = res;
    func_n = func_q; dext_n = dext_q; idx_n = idx_q;
    case (state_q)
      ST_IDLE: if (go) begin
        state_n = ST_BUSY;
        cnt_n   = lat_m1;
        func_n  = func;
        dext_n  = dst_ext;
        idx_n   = idx_d;
      end
      ST_BUSY: if (cnt_q == '0) begin
        state_n = ST_IDLE;
        fin_n   = 1'b1;
        res_n   = final_res;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; cnt_q <= '0; fin <= 1'b0; res <= '0;
      func_q <= '0; dext_q <= 1'b0; idx_q <= '0;
    end else if (ce) begin
      state_q <= state_n; cnt_q <= cnt_n; fin <= fin_n; res <= res_n;
      func_q <= func_n; dext_q <= dext_n; idx_q <= idx_n;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && ce) |=> !fin); // R8
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> $stable(res)); // R8
  AST_CE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(state_q) && $stable(cnt_q) && $stable(fin) && $stable(res)); // R9
  AST_MUL_START: assert property (@(posedge clk) disable iff (!rst_n)
    (load && func == FN_MUL) |=> (state_q == ST_BUSY) && (cnt_q == ITER_W'(MUL_LAT - 1))); // R3
  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY) |-> !go); // R8
endmodule

// File: rtl/ci_accel.sv
module ci_accel
  import ci_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int RF_DEPTH = 32,
  parameter int ITER_W   = 6,
  parameter int MUL_LAT  = 3,
  localparam int IDX_W   = $clog2(RF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              go,
  input  logic [FUNC_W-1:0] func,
  input  logic [XLEN-1:0]   op_a_ext,
  input  logic [XLEN-1:0]   op_b_ext,
  input  logic [IDX_W-1:0]  idx_a,
  input  logic [IDX_W-1:0]  idx_b,
  input  logic [IDX_W-1:0]  idx_d,
  input  logic              sel_a_ext,
  input  logic              sel_b_ext,
  input  logic              dst_ext,
  output logic              fin,
  output logic [XLEN-1:0]   res
);
  logic [XLEN-1:0]   ext_op [2];
  logic [XLEN-1:0]   loc_op [2];
  logic [XLEN-1:0]   opnd   [2];
  logic              sel    [2];
  logic              load, step, wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [FUNC_W-1:0] func_q;
  logic [XLEN-1:0]   final_res;

  assign ext_op[0] = op_a_ext;
  assign ext_op[1] = op_b_ext;
  assign sel[0]    = sel_a_ext;
  assign sel[1]    = sel_b_ext;

  for (genvar g = 0; g < 2; g++) begin : g_src
    assign opnd[g] = sel[g] ? ext_op[g] : loc_op[g];
  end

  ci_regfile #(.XLEN(XLEN), .DEPTH(RF_DEPTH)) u_rf (
    .clk(clk), .rst_n(rst_n), .ce(ce),
    .rd_idx_a(idx_a), .rd_idx_b(idx_b), .rd_a(loc_op[0]), .rd_b(loc_op[1]),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(final_res)
  );

  ci_datapath #(.XLEN(XLEN), .ITER_W(ITER_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .func_q(func_q),
    .opa_in(opnd[0]), .opb_in(opnd[1]), .final_res(final_res)
  );

  ci_ctrl #(.XLEN(XLEN), .IDX_W(IDX_W), .ITER_W(ITER_W), .MUL_LAT(MUL_LAT)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ce(ce), .go(go), .func(func),
    .iter_k(opnd[1][ITER_W-1:0]), .dst_ext(dst_ext), .idx_d(idx_d),
    .final_res(final_res), .load(load), .step(step), .func_q(func_q),
    .wr_en(wr_en), .wr_idx(wr_idx), .fin(fin), .res(res)
  );

  AST_SRC_A: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !sel_a_ext) |-> opnd[0] == loc_op[0]); // R6
endmodule

// File: tb/ci_accel_bench.sv
module ci_accel_bench;
  logic        clk = 1'b0;
  logic        rst_n, ce, go, sel_a_ext, sel_b_ext, dst_ext, fin;
  logic [7:0]  func;
  logic [31:0] op_a_ext, op_b_ext, res;
  logic [4:0]  idx_a, idx_b, idx_d;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [31:0] mdl [32];

  typedef struct { logic [31:0] val; int lat; int start; string tag; } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  ci_accel u_ci_accel (
    .clk(clk), .rst_n(rst_n), .ce(ce), .go(go), .func(func),
    .op_a_ext(op_a_ext), .op_b_ext(op_b_ext), .idx_a(idx_a), .idx_b(idx_b),
    .idx_d(idx_d), .sel_a_ext(sel_a_ext), .sel_b_ext(sel_b_ext),
    .dst_ext(dst_ext), .fin(fin), .res(res)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // monitor: pops expectations when fin shows up, checks pulse end and hold
  logic        prev_fin = 1'b0;
  logic [31:0] prev_res = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_fin && ce) begin
        check(!fin, "R8 fin pulse width", 32'(fin), 32'h0);
        check(res == prev_res, "R8 res hold", res, prev_res);
      end
      if (fin) begin
        if (exp_q.size() == 0) check(1'b0, "R8 unexpected fin", 32'h1, 32'h0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(res == e.val, e.tag, res, e.val);
          check(cyc - e.start == e.lat, {e.tag, " latency"}, 32'(cyc - e.start), 32'(e.lat));
        end
      end
    end
    prev_fin = fin;
    prev_res = res;
  end

  always @(posedge clk) if (cyc > 20000) begin
    check(1'b0, "watchdog", 32'(cyc), 32'd20000);
    finish_run();
  end

  function automatic logic [31:0] acc_shift(logic [31:0] a, int k);
    logic [31:0] s = '0;
    for (int i = 0; i < k; i++) s = s + (a << i);
    return s;
  endfunction

  task automatic run(input logic [7:0] f, input bit sa, input bit sb,
                     input logic [31:0] ea, input logic [31:0] eb,
                     input logic [4:0] ia, input logic [4:0] ib,
                     input bit dx, input logic [4:0] id, input int stall,
                     input string tag);
    logic [31:0] va, vb, ev;
    int lat, k;
    exp_t e;
    va = sa ? ea : mdl[ia];
    vb = sb ? eb : mdl[ib];
    k  = int'(vb[5:0]);
    case (f)
      8'h00:   begin ev = va + vb; lat = 1; end
      8'h01:   begin ev = va * vb; lat = 3; end
      8'h02:   begin ev = acc_shift(va, k); lat = (k == 0) ? 1 : k; end
      default: begin ev = '0; lat = 1; end
    endcase
    lat = lat + stall;
    func = f; sel_a_ext = sa; sel_b_ext = sb; op_a_ext = ea; op_b_ext = eb;
    idx_a = ia; idx_b = ib; dst_ext = dx; idx_d = id; go = 1'b1; ce = 1'b1;
    @(posedge clk);
    @(negedge clk);
    e.val = ev; e.lat = lat; e.start = cyc; e.tag = tag;
    exp_q.push_back(e);
    go = 1'b0;
    op_a_ext = ~ea; op_b_ext = eb ^ 32'h5A5A_0F0F;  // R10: port changes after capture
    sel_a_ext = ~sa; sel_b_ext = ~sb; idx_a = ~ia; idx_b = ~ib;
    if (stall > 0) begin
      @(negedge clk);
      ce = 1'b0;
      repeat (stall) @(negedge clk);
      ce = 1'b1;
    end
    while (!fin) @(negedge clk);
    if (!dx) mdl[id] = ev;
    @(negedge clk);
  endtask

  // R1/R7 readback: add local register idx with external zero, result to port
  task automatic peek(input logic [4:0] idx, input string tag);
    run(8'h00, 1'b0, 1'b1, '0, '0, idx, '0, 1'b1, 5'd0, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    rst_n = 1'b0; ce = 1'b0; go = 1'b0; func = '0; op_a_ext = '0; op_b_ext = '0;
    idx_a = '0; idx_b = '0; idx_d = '0; sel_a_ext = 1'b0; sel_b_ext = 1'b0; dst_ext = 1'b1;
    repeat (3) @(negedge clk);
    check(fin == 1'b0, "R1 fin in reset", 32'(fin), 32'h0);
    check(res == '0, "R1 res in reset", res, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(fin == 1'b0 && res == '0, "R1 after reset", res, 32'h0);
    peek(5'd0,  "R1 reg0 cleared");
    peek(5'd31, "R1 reg31 cleared");

    run(8'h00, 1, 1, 32'hFFFF_FFFF, 32'd2, 0, 0, 1, 0, 0, "R2 add wrap");
    run(8'h00, 1, 1, 32'd100, 32'd23, 0, 0, 0, 5'd5, 0, "R2 R7 add to local");
    peek(5'd5, "R7 local write reg5");
    run(8'h01, 0, 1, 32'd0, 32'd3, 5'd5, 0, 1, 0, 0, "R3 R6 mul local x ext");
    run(8'h01, 1, 1, 32'h0001_0000, 32'h0001_0000, 0, 0, 0, 5'd31, 0, "R3 mul overflow");
    peek(5'd31, "R7 reg31 product");
    run(8'h01, 1, 1, 32'h1234_5678, 32'h9ABC_DEF1, 0, 0, 1, 0, 0, "R3 mul wide");
    run(8'h02, 1, 1, 32'd5, 32'd4, 0, 0, 0, 5'd2, 0, "R4 acc k=4");
    run(8'h02, 1, 1, 32'd9, 32'd0, 0, 0, 1, 0, 0, "R4 acc k=0");
    run(8'h02, 1, 1, 32'd7, 32'd1, 0, 0, 1, 0, 0, "R4 acc k=1");
    run(8'h02, 1, 1, 32'd1, 32'h0000_013F, 0, 0, 1, 0, 0, "R4 acc k=63");
    run(8'h02, 1, 1, 32'd3, 32'h0000_0040, 0, 0, 1, 0, 0, "R4 acc upper bits ignored");
    run(8'h7F, 1, 1, 32'd11, 32'd12, 0, 0, 1, 0, 0, "R5 unknown code");
    run(8'hFF, 1, 1, 32'd1, 32'd1, 0, 0, 0, 5'd7, 0, "R5 unknown to local");
    peek(5'd7, "R5 R7 reg7 zero");
    run(8'h00, 0, 0, 0, 0, 5'd2, 5'd5, 1, 0, 0, "R6 local+local to port");
    run(8'h00, 0, 1, 0, 32'd1000, 5'd2, 0, 0, 5'd9, 0, "R6 local+ext to local");
    peek(5'd9, "R6 reg9");
    run(8'h00, 1, 0, 32'd1, 0, 0, 5'd9, 1, 5'd5, 0, "R7 ext dest with idx_d=5");
    peek(5'd5, "R7 reg5 untouched");
    run(8'h01, 1, 1, 32'd7, 32'd6, 0, 0, 1, 0, 4, "R9 mul stalled");
    run(8'h02, 0, 1, 0, 32'd5, 5'd2, 0, 0, 5'd12, 3, "R9 R10 acc stalled");
    peek(5'd12, "R9 reg12");

    // R9: go while ce low is ignored
    ce = 1'b0; go = 1'b1; func = 8'h00; sel_a_ext = 1; sel_b_ext = 1;
    op_a_ext = 32'd5; op_b_ext = 32'd6; dst_ext = 1'b0; idx_d = 5'd3;
    repeat (3) begin
      @(negedge clk);
      check(fin == 1'b0, "R9 go ignored while ce low", 32'(fin), 32'h0);
    end
    go = 1'b0; ce = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(fin == 1'b0, "R9 no late start", 32'(fin), 32'h0);
    end
    peek(5'd3, "R9 reg3 unchanged");

    @(negedge clk);
    check(exp_q.size() == 0, "R8 all results seen", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule